// File: doc/BRIEF.md
# RC Oscillator Trim Calibrator

This block searches for the trim setting of an on-chip RC oscillator. It measures the oscillator against the reference clock and adjusts the trim until the two agree. The search variable is a signed integer. The block turns it into a 28-bit trim word made of seven 4-bit digits and drives that word to the oscillator. It then runs a counter measurement and steers the variable from the signed count error. The search always takes a fixed number of halving steps. At the end the block presents the final word with the enable bit set and raises a done flag.

The oscillator edges arrive as `rc_edge_i`, one single-cycle pulse per RC edge, already in the control clock domain. The measurement counter inside the block is cleared and then loaded. It is then started through a two-stage start pipeline. While its window is open it counts down on RC edges and counts up on every second system cycle. A software driver or a boot sequencer pulses `start_i` and waits for `done_o`.

Top module: `rc_trim_cal`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are: trim word 0, enable 0, done 0.
- R2: A start pulse taken while idle or finished clears done on the next edge. The search value becomes -4 with a step size of 53.
- R3: Encoding of value v: b = floor(v/7) and m = v - 7b (0..6). Digit d of the word, at bits [4d+3:4d] for d = 0..6, is (b+1) mod 16 when d < m and b mod 16 otherwise. For example, -4 gives 28'hFFFF000, 45 gives 28'h6666777, -50 gives 28'h8999999 and 22 gives 28'h3333334.
- R4: Each measurement follows a fixed order. The counter is cleared, then loaded with 2048, then started. The window lasts WIN_CYC cycles. The error is 2048 minus the final count, which equals the number of RC edges seen in the window minus WIN_CYC/2.
- R5: The counter sees a start request two cycles after it is issued. A step is taken only after the counter's done has been seen low and then high. One step takes WIN_CYC+7 cycles, so a run from start to done takes 8*(WIN_CYC+7) cycles.
- R6: When the error is above +12, the value drops by floor(size/2). When the error is below -12, the value rises by floor(size/2). An error from -12 to +12 inclusive leaves the value unchanged.
- R7: After each step the size becomes (size+1)>>1. Exactly 8 steps are run.
- R8: The enable bit is 0 throughout the search. The final word, enable=1 and done=1 all appear on the same edge.
- R9: A start pulse during a search is ignored. The search neither restarts nor stretches.
- R10: Done stays high until the next start pulse.
- R11: The search value always stays within -56..49.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-cycle calibration request |
| rc_edge_i | input | 1 | One pulse per RC oscillator edge, already synchronous |
| trim_word_o | output | 28 | Seven 4-bit trim digits driven to the oscillator |
| trim_en_o | output | 1 | Enable/lock bit of the trim word |
| done_o | output | 1 | Calibration finished; sticky until next start |

## Verification
The bench models the oscillator as an edge rate that varies linearly with the decoded trim value. It tries five targets and slopes. A mid-range target shows that the search converges. Targets near the top and bottom of the range exercise the largest digit wrap and the value limits. One target leaves the error at exactly -12 near the end of the search, and another gives exactly +12 on the first step. Both show that the deadband is inclusive and that the error is counted exactly. A shallow slope lets the search settle early. A start pulse issued in mid-run shows whether it is ignored, through the trim sequence and the total duration.

// File: rtl/rtc_pkg.sv
// Shared constants and types of the RC trim calibrator.
// Assumes: trim geometry is fixed by the oscillator (7 digits of 4 bits).
package rtc_pkg;
    localparam int DIGITS    = 7;
    localparam int DIG_W     = 4;
    localparam int WORD_W    = DIGITS * DIG_W;
    localparam int VAL_W     = 8;
    localparam int VAL_MIN   = -8 * DIGITS;
    localparam int VAL_MAX   = 7 * DIGITS;
    localparam int SPAN      = VAL_MAX - VAL_MIN + 1;
    localparam int SIZE_INIT = SPAN / 2;
    localparam int VAL_INIT  = VAL_MAX - SIZE_INIT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_LOAD,
        ST_START,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_STEP,
        ST_DONE
    } cal_state_e;
endpackage

// File: rtl/trim_encoder.sv
// Turns a signed search value into a multi-digit trim word.
// Uses floor division, so the remainder is always 0..DIGITS-1. Low-order
// digits receive the +1 share. Each digit keeps its low DIG_W bits.
// Assumes: purely combinational, value within the search range.
module trim_encoder #(
    parameter int DIGITS = 7,
    parameter int DIG_W  = 4,
    parameter int VAL_W  = 8
) (
    input  logic signed [VAL_W-1:0]        val_i,
    output logic        [DIGITS*DIG_W-1:0] word_o
);
    localparam logic signed [VAL_W-1:0] DIV = VAL_W'(DIGITS);

    logic signed [VAL_W-1:0] tq, tr, fq, fr, fq1;

    // Floor quotient and non-negative remainder.
    always_comb begin
        tq = val_i / DIV;
        tr = val_i % DIV;
        if (tr < 0) begin
            fq = tq - VAL_W'(1);
            fr = tr + DIV;
        end else begin
            fq = tq;
            fr = tr;
        end
        fq1 = fq + VAL_W'(1);
    end

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
        // Digits below the remainder carry one extra step.
        assign word_o[gi*DIG_W +: DIG_W] = (gi < int'(fr)) ? fq1[DIG_W-1:0] : fq[DIG_W-1:0];
    end
endmodule

// File: rtl/meas_window.sv
// Counter-window measurement of the RC oscillator.
// Operations: an active-low clear, a load of LOAD_VAL, and a start that
// reaches the counter after two pipeline stages. During WIN_CYC cycles the
// count falls by one per RC edge and rises by one every second cycle.
// done_o is high when no window is open (also out of reset).
// Assumes: rc_edge_i already synchronous to clk.
module meas_window #(
    parameter int LOAD_VAL = 2048,
    parameter int WIN_CYC  = 4096,
    parameter int CNT_W    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n_i,
    input  logic             load_i,
    input  logic             start_i,
    input  logic             rc_edge_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);
    localparam int WIN_W = $clog2(WIN_CYC);

    logic             st1_q, st2_q, run_q;
    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] cnt_q;

    // Start pipeline, command decode and window counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1_q  <= 1'b0;
            st2_q  <= 1'b0;
            run_q  <= 1'b0;
            win_q  <= '0;
            cnt_q  <= '0;
            done_o <= 1'b1;
        end else begin
            st1_q <= start_i;
            st2_q <= st1_q;
            if (!clr_n_i) begin
                cnt_q <= '0;
                run_q <= 1'b0;
                win_q <= '0;
            end else if (load_i) begin
                cnt_q <= CNT_W'(LOAD_VAL);
            end else if (st2_q) begin
                run_q  <= 1'b1;
                done_o <= 1'b0;
                win_q  <= '0;
            end else if (run_q) begin
                cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, win_q[0]} - {{(CNT_W-1){1'b0}}, rc_edge_i};
                win_q <= win_q + WIN_W'(1);
                if (win_q == WIN_W'(WIN_CYC - 1)) begin
                    run_q  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign count_o = cnt_q;

    // R5: the start request lowers done three edges after it is sampled.
    assert_start_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && clr_n_i) |=> ##2 !done_o);

    // R4: with no window open and no command, the count holds.
    assert_count_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !st2_q && clr_n_i && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/rtc_search.sv
// Binary-search sequencer of the RC trim calibrator.
// Runs ITERS measurement steps. Each step clears, loads and starts the
// counter, waits for its done low then high, then moves the value by
// half the step size unless the error is inside the deadband.
// Assumes: the counter keeps done high when idle.
module rtc_search
    import rtc_pkg::*;
#(
    parameter int ITERS    = 8,
    parameter int DEADBAND = 12,
    parameter int LOAD_VAL = 2048,
    parameter int CNT_W    = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    meas_done_i,
    input  logic [CNT_W-1:0]        meas_count_i,
    output logic                    ctr_clr_n_o,
    output logic                    ctr_load_o,
    output logic                    ctr_start_o,
    output logic signed [VAL_W-1:0] val_o,
    output logic                    en_o,
    output logic                    done_o
);
    localparam int SZ_W = $clog2(SIZE_INIT + 1);
    localparam int IT_W = $clog2(ITERS + 1);
    localparam logic signed [VAL_W-1:0] VMIN_S = VAL_W'(VAL_MIN);
    localparam logic signed [VAL_W-1:0] VMAX_S = VAL_W'(VAL_MAX);
    localparam logic signed [CNT_W:0]   DB_S   = (CNT_W+1)'(DEADBAND);
    localparam logic signed [CNT_W:0]   LOAD_S = (CNT_W+1)'(LOAD_VAL);

    cal_state_e              st_q;
    logic [SZ_W-1:0]         size_q;
    logic [IT_W-1:0]         iter_q;
    logic signed [VAL_W-1:0] val_q, half_s;
    logic signed [CNT_W:0]   cnt_s, err_s;
    logic                    in_band, busy;

    // Signed count error and deadband test.
    always_comb begin
        cnt_s   = {meas_count_i[CNT_W-1], meas_count_i};
        err_s   = LOAD_S - cnt_s;
        in_band = (err_s <= DB_S) && (err_s >= -DB_S);
        half_s  = VAL_W'(size_q >> 1);
    end

    assign busy        = (st_q != ST_IDLE) && (st_q != ST_DONE);
    assign ctr_clr_n_o = (st_q != ST_CLR);
    assign ctr_load_o  = (st_q == ST_LOAD);
    assign ctr_start_o = (st_q == ST_START);
    assign val_o       = val_q;

    // Sequencing of the measurement steps and the search update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            size_q <= '0;
            iter_q <= '0;
            val_q  <= '0;
            en_o   <= 1'b0;
            done_o <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (start_i) begin
                        val_q  <= VAL_W'(VAL_INIT);
                        size_q <= SZ_W'(SIZE_INIT);
                        iter_q <= '0;
                        en_o   <= 1'b0;
                        done_o <= 1'b0;
                        st_q   <= ST_CLR;
                    end
                end
                ST_CLR:     st_q <= ST_LOAD;
                ST_LOAD:    st_q <= ST_START;
                ST_START:   st_q <= ST_WAIT_LO;
                ST_WAIT_LO: if (!meas_done_i) st_q <= ST_WAIT_HI;
                ST_WAIT_HI: if (meas_done_i)  st_q <= ST_STEP;
                ST_STEP: begin
                    if (!in_band) begin
                        if (err_s > 0) val_q <= val_q - half_s;
                        else           val_q <= val_q + half_s;
                    end
                    size_q <= SZ_W'((size_q + SZ_W'(1)) >> 1);
                    iter_q <= iter_q + IT_W'(1);
                    if (iter_q == IT_W'(ITERS - 1)) begin
                        en_o   <= 1'b1;
                        done_o <= 1'b1;
                        st_q   <= ST_DONE;
                    end else begin
                        st_q <= ST_CLR;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assert_en_low_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !en_o);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    assert_deadband_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STEP && in_band) |=> $stable(val_o));

    assert_iter_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (iter_q == IT_W'(ITERS)));

    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_HI && start_i && !meas_done_i) |=> (st_q == ST_WAIT_HI));

    assert_load_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_load_o |-> $past(!ctr_clr_n_o));

    assert_value_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (val_o >= VMIN_S) && (val_o <= VMAX_S));
endmodule

// File: rtl/rc_trim_cal.sv
// RC oscillator trim calibrator top: search sequencer, measurement
// counter window and trim-word encoder.
// Assumes: single clock domain; rc_edge_i pulses are already synchronous.
module rc_trim_cal
    import rtc_pkg::*;
#(
    parameter int WIN_CYC  = 4096,
    parameter int LOAD_VAL = 2048,
    parameter int DEADBAND = 12,
    parameter int ITERS    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rc_edge_i,
    output logic [WORD_W-1:0] trim_word_o,
    output logic              trim_en_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(LOAD_VAL + WIN_CYC) + 2;

    logic                    clr_n, load, mstart, mdone;
    logic [CNT_W-1:0]        mcount;
    logic signed [VAL_W-1:0] val;

    rtc_search #(
        .ITERS(ITERS), .DEADBAND(DEADBAND), .LOAD_VAL(LOAD_VAL), .CNT_W(CNT_W)
    ) u_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .meas_done_i(mdone), .meas_count_i(mcount),
        .ctr_clr_n_o(clr_n), .ctr_load_o(load), .ctr_start_o(mstart),
        .val_o(val), .en_o(trim_en_o), .done_o(done_o)
    );

    meas_window #(
        .LOAD_VAL(LOAD_VAL), .WIN_CYC(WIN_CYC), .CNT_W(CNT_W)
    ) u_meas (
        .clk(clk), .rst_n(rst_n), .clr_n_i(clr_n), .load_i(load),
        .start_i(mstart), .rc_edge_i(rc_edge_i),
        .count_o(mcount), .done_o(mdone)
    );

    trim_encoder #(
        .DIGITS(DIGITS), .DIG_W(DIG_W), .VAL_W(VAL_W)
    ) u_enc (
        .val_i(val), .word_o(trim_word_o)
    );
endmodule

// File: tb/rc_trim_cal_test.sv
module rc_trim_cal_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 1024;
    localparam int REFN = WIN / 2;
    localparam int DB   = 12;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, rc_edge = 1'b0;
    logic [27:0] trim_word;
    logic        trim_en, done;

    int checks = 0, errors = 0, cyc = 0;
    int osc_v0 = 0, osc_k = 3, acc = 0;
    bit mon_on = 1'b0, finished = 1'b0;
    logic [27:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rc_trim_cal #(.WIN_CYC(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rc_edge_i(rc_edge),
        .trim_word_o(trim_word), .trim_en_o(trim_en), .done_o(done)
    );

    function automatic logic [27:0] enc_ref(int v);
        int b, m;
        logic [27:0] w;
        b = (v >= 0) ? v / 7 : -((6 - v) / 7);
        m = v - 7 * b;
        w = '0;
        for (int d = 0; d < 7; d++) w[4*d +: 4] = 4'((d < m) ? b + 1 : b);
        return w;
    endfunction

    function automatic int dec(logic [27:0] w);
        int s = 0;
        for (int d = 0; d < 7; d++) begin
            int n = int'(w[4*d +: 4]);
            s += (n >= 8) ? n - 16 : n;
        end
        return s;
    endfunction

    task automatic check(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Oscillator model: edges per window grow linearly with the trim value.
    initial forever begin
        int n;
        @(negedge clk);
        n = REFN + osc_k * (dec(trim_word) - osc_v0);
        if (n < 0) n = 0;
        if (n > WIN) n = WIN;
        acc += n;
        if (acc >= WIN) begin
            acc -= WIN;
            rc_edge = 1'b1;
        end else begin
            rc_edge = 1'b0;
        end
    end

    // Reference model compared on every clock while a search runs.
    initial forever begin
        @(negedge clk);
        if (mon_on) begin
            if (exp_q.size() > 1 && trim_word != exp_q[0] && trim_word == exp_q[1])
                void'(exp_q.pop_front());
            check(trim_word == exp_q[0], "R6 R7 trim sequence", trim_word, exp_q[0]);
            if (!done) check(trim_en == 1'b0, "R8 enable clear while searching", trim_en, 0);
        end
    end

    task automatic expect_search(int v0, int k, output int vfin);
        int v = -4, size = 53, e;
        exp_q.delete();
        exp_q.push_back(enc_ref(v));
        for (int it = 0; it < 8; it++) begin
            e = k * (v - v0);
            if (e > DB || e < -DB) v = (e > 0) ? v - size / 2 : v + size / 2;
            size = (size + 1) / 2;
            if (enc_ref(v) != exp_q[$]) exp_q.push_back(enc_ref(v));
        end
        vfin = v;
    endtask

    task automatic run_cal(int v0, int k, bit poke, output int vfin);
        int t0, guard;
        osc_v0 = v0;
        osc_k  = k;
        expect_search(v0, k, vfin);
        @(negedge clk);
        start = 1'b1;
        t0 = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R2 R10 done cleared by start", done, 0);
        check(trim_word == 28'hFFFF000, "R2 R3 initial word for -4", trim_word, 28'hFFFF000);
        check(trim_en == 1'b0, "R8 enable cleared at start", trim_en, 0);
        mon_on = 1'b1;
        if (poke) begin
            repeat (3000) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(done == 1'b0, "R9 start ignored mid-run", done, 0);
        end
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        mon_on = 1'b0;
        if (exp_q.size() > 1 && trim_word == exp_q[1]) void'(exp_q.pop_front());
        check(cyc - t0 == 8 * (WIN + 7), "R5 R9 run duration", cyc - t0, 8 * (WIN + 7));
        check(exp_q.size() == 1, "R7 all steps taken", exp_q.size(), 1);
        check(trim_word == enc_ref(vfin), "R3 R8 final word", trim_word, enc_ref(vfin));
        check(trim_en == 1'b1, "R8 enable set at end", trim_en, 1);
        check(k * (dec(trim_word) - v0) <= DB && k * (dec(trim_word) - v0) >= -DB,
              "R4 R6 final error within deadband", dec(trim_word), v0);
        check(vfin >= -56 && vfin <= 49, "R11 value range", vfin, 0);
        repeat (40) @(negedge clk);
        check(done == 1'b1 && trim_en == 1'b1, "R10 done sticky", done, 1);
    endtask

    initial begin
        int vf;
        repeat (5) @(negedge clk);
        check(trim_word == 28'h0 && trim_en == 1'b0 && done == 1'b0, "R1 state in reset",
              {trim_en, done, trim_word}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(trim_word == 28'h0 && trim_en == 1'b0 && done == 1'b0, "R1 state after reset",
              {trim_en, done, trim_word}, 0);

        run_cal(17, 3, 1'b1, vf);
        check(vf == 16, "R6 mid-range result", vf, 16);
        run_cal(49, 3, 1'b0, vf);
        check(trim_word == 28'h6666777, "R3 R6 word at -12 boundary", trim_word, 28'h6666777);
        run_cal(-8, 3, 1'b0, vf);
        check(trim_word == 28'hFFFF000, "R6 +12 boundary holds", trim_word, 28'hFFFF000);
        run_cal(-50, 3, 1'b0, vf);
        check(trim_word == 28'h8999999, "R3 R11 low end word", trim_word, 28'h8999999);
        run_cal(30, 1, 1'b0, vf);
        check(trim_word == 28'h3333334, "R3 R6 shallow slope word", trim_word, 28'h3333334);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule